// File: doc/BRIEF.md
# Dual-Algorithm Message Hash Engine (SHA-1 / MD5)

This block computes a SHA-1 or an MD5 digest of a byte message. The algorithm is chosen per message when the message is started, and the message length in bytes is given at the same time. Both algorithms share a single 32-bit compression datapath and a single 16-word schedule window. Message words arrive 32 bits at a time on a valid/ready pair. The block pads the message in hardware: it appends the marker bit and the zero fill, then writes the 64-bit bit count into the final two word slots. A word counter and a held copy of the byte length drive this padding logic.

For each step, the schedule unit supplies the message word and the constants unit supplies the round constant and the rotate amount. The compression datapath runs one step per clock: 80 steps per 512-bit block for SHA-1 and 64 steps for MD5. When the final block has been folded into the 160-bit chaining register, a done flag rises. The digest is then held until the next start. This engine sits below an HMAC wrapper, which owns the key handling and the bus attachment.

Top module: `dual_hash_engine`

## Requirements
- R1: While reset is held, and right after it is released, `done`, `busy` and `in_ready` are low and `digest` is all zeros.
- R2: With `algo_sel`=0 (SHA-1), `digest[159:0]` is the SHA-1 value with the first word of the result in bits [159:128], matching the usual hex string read left to right.
- R3: With `algo_sel`=1 (MD5), `digest[127:0]` holds the MD5 value in the byte order of its usual hex string, with the first byte in bits [127:120], and `digest[159:128]` is zero.
- R4: Each input word carries message bytes in arrival order, with the first byte in bits [31:24]. In the last word of a message whose length is not a multiple of 4, the bytes after the message end are ignored.
- R5: Exactly ceil(msg_len/4) words are accepted per message. `in_ready` is high only while the engine is busy and still needs message bytes, and it is low after the digest is complete.
- R6: Padding is correct for an empty message. A message with msg_len mod 64 >= 56 gets one extra block that holds only padding.
- R7: For a single-block message with no input stalls, `done` is high after the 96th rising edge that follows the edge capturing `start` with SHA-1, and after the 80th such edge with MD5. Each step therefore takes one cycle.
- R8: Once `done` is high, it stays high and `digest` stays unchanged until a new `start` is accepted. The accepted `start` clears `done` on the next edge.
- R9: A `start` that arrives while `busy` is high is ignored, together with the `algo_sel` and `msg_len` that come with it.
- R10: Holding `in_valid` low stalls the engine without changing the result.
- R11: Messages hashed back to back may alternate between the two algorithms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a message when the engine is idle |
| algo_sel | input | 1 | 0 = SHA-1, 1 = MD5, captured with start |
| msg_len | input | LEN_W | Message length in bytes, captured with start |
| in_valid | input | 1 | in_data holds a message word |
| in_data | input | 32 | Message word, first byte in [31:24] |
| in_ready | output | 1 | Engine takes in_data on this edge if in_valid |
| busy | output | 1 | A message is being padded or compressed |
| done | output | 1 | Digest complete and held |
| digest | output | 160 | Result (see R2, R3) |

## Verification
Embedded assertions check the following properties on every cycle:
- `in_ready` is never high while the engine is idle.
- The length slots of the final block never take input.
- The schedule window is never refilled during compression.
- The step index stays within the algorithm's step count.
- The chaining words change only at a block end or a message start.
- `done` and `digest` hold steady.
- A start during a busy period does not change the captured algorithm.

Only the bench scenarios can show that the digests are correct. The bench compares each result against published test vectors: empty, three-byte and multi-block messages for both algorithms. These scenarios also cover the 56-byte padding boundary, masking of stray trailing bytes, accepted-word counts, input stalls, single-block latency, and a stray start in the middle of a message.

// File: rtl/dual_hash_pkg.sv
package dual_hash_pkg;

  localparam int WORD_W = 32;
  localparam int STEP_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RUN  = 2'd2
  } eng_state_t;

  localparam logic ALG_SHA1 = 1'b0;
  localparam logic ALG_MD5  = 1'b1;

  function automatic logic [31:0] rotl32(input logic [31:0] x, input logic [4:0] n);
    return (x << n) | (x >> (6'd32 - {1'b0, n}));
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  // SHA-1 boolean function for step t
  function automatic logic [31:0] sha1_f(input logic [6:0] t, input logic [31:0] b,
                                         input logic [31:0] c, input logic [31:0] d);
    if (t < 7'd20)      return (b & c) | (~b & d);
    else if (t < 7'd40) return b ^ c ^ d;
    else if (t < 7'd60) return (b & c) | (b & d) | (c & d);
    else                return b ^ c ^ d;
  endfunction

  function automatic logic [31:0] sha1_k(input logic [6:0] t);
    if (t < 7'd20)      return 32'h5a827999;
    else if (t < 7'd40) return 32'h6ed9eba1;
    else if (t < 7'd60) return 32'h8f1bbcdc;
    else                return 32'hca62c1d6;
  endfunction

  // MD5 boolean function for step t (t < 64)
  function automatic logic [31:0] md5_f(input logic [6:0] t, input logic [31:0] b,
                                        input logic [31:0] c, input logic [31:0] d);
    case (t[5:4])
      2'd0:    return (b & c) | (~b & d);
      2'd1:    return (d & b) | (~d & c);
      2'd2:    return b ^ c ^ d;
      default: return c ^ (b | ~d);
    endcase
  endfunction

  // MD5 message word index for step t
  function automatic logic [3:0] md5_idx(input logic [6:0] t);
    int v;
    case (t[5:4])
      2'd0:    v = int'(t);
      2'd1:    v = 5 * int'(t) + 1;
      2'd2:    v = 3 * int'(t) + 5;
      default: v = 7 * int'(t);
    endcase
    return v[3:0];
  endfunction

  function automatic logic [4:0] md5_shift(input logic [6:0] t);
    case ({t[5:4], t[1:0]})
      4'h0: return 5'd7;   4'h1: return 5'd12;  4'h2: return 5'd17;  4'h3: return 5'd22;
      4'h4: return 5'd5;   4'h5: return 5'd9;   4'h6: return 5'd14;  4'h7: return 5'd20;
      4'h8: return 5'd4;   4'h9: return 5'd11;  4'ha: return 5'd16;  4'hb: return 5'd23;
      4'hc: return 5'd6;   4'hd: return 5'd10;  4'he: return 5'd15;  default: return 5'd21;
    endcase
  endfunction

  // Integer part of |sin(t+1)| * 2^32, one per MD5 step
  function automatic logic [31:0] md5_k(input logic [5:0] t);
    case (t)
      6'd0:  return 32'hd76aa478; 6'd1:  return 32'he8c7b756; 6'd2:  return 32'h242070db; 6'd3:  return 32'hc1bdceee;
      6'd4:  return 32'hf57c0faf; 6'd5:  return 32'h4787c62a; 6'd6:  return 32'ha8304613; 6'd7:  return 32'hfd469501;
      6'd8:  return 32'h698098d8; 6'd9:  return 32'h8b44f7af; 6'd10: return 32'hffff5bb1; 6'd11: return 32'h895cd7be;
      6'd12: return 32'h6b901122; 6'd13: return 32'hfd987193; 6'd14: return 32'ha679438e; 6'd15: return 32'h49b40821;
      6'd16: return 32'hf61e2562; 6'd17: return 32'hc040b340; 6'd18: return 32'h265e5a51; 6'd19: return 32'he9b6c7aa;
      6'd20: return 32'hd62f105d; 6'd21: return 32'h02441453; 6'd22: return 32'hd8a1e681; 6'd23: return 32'he7d3fbc8;
      6'd24: return 32'h21e1cde6; 6'd25: return 32'hc33707d6; 6'd26: return 32'hf4d50d87; 6'd27: return 32'h455a14ed;
      6'd28: return 32'ha9e3e905; 6'd29: return 32'hfcefa3f8; 6'd30: return 32'h676f02d9; 6'd31: return 32'h8d2a4c8a;
      6'd32: return 32'hfffa3942; 6'd33: return 32'h8771f681; 6'd34: return 32'h6d9d6122; 6'd35: return 32'hfde5380c;
      6'd36: return 32'ha4beea44; 6'd37: return 32'h4bdecfa9; 6'd38: return 32'hf6bb4b60; 6'd39: return 32'hbebfbc70;
      6'd40: return 32'h289b7ec6; 6'd41: return 32'heaa127fa; 6'd42: return 32'hd4ef3085; 6'd43: return 32'h04881d05;
      6'd44: return 32'hd9d4d039; 6'd45: return 32'he6db99e5; 6'd46: return 32'h1fa27cf8; 6'd47: return 32'hc4ac5665;
      6'd48: return 32'hf4292244; 6'd49: return 32'h432aff97; 6'd50: return 32'hab9423a7; 6'd51: return 32'hfc93a039;
      6'd52: return 32'h655b59c3; 6'd53: return 32'h8f0ccc92; 6'd54: return 32'hffeff47d; 6'd55: return 32'h85845dd1;
      6'd56: return 32'h6fa87e4f; 6'd57: return 32'hfe2ce6e0; 6'd58: return 32'ha3014314; 6'd59: return 32'h4e0811a1;
      6'd60: return 32'hf7537e82; 6'd61: return 32'hbd3af235; 6'd62: return 32'h2ad7d2bb; default: return 32'heb86d391;
    endcase
  endfunction

endpackage

// File: rtl/dual_hash_pad.sv
module dual_hash_pad
  import dual_hash_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             algo,
  input  logic             advance,
  input  logic [31:0]      in_data,
  output logic             need_in,
  output logic [31:0]      word,
  output logic [3:0]       slot,
  output logic             blk_last
);
  localparam int CW = LEN_W + 2;

  logic [LEN_W-1:0] len_q, wcnt_q;
  logic [CW-1:0]    base, lenx, last_idx, blk_idx, rem;
  logic [63:0]      bitlen;
  logic             len_slot;
  logic [31:0]      stream_w, len_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      wcnt_q <= '0;
    end else if (load) begin
      len_q  <= len_in;
      wcnt_q <= '0;
    end else if (advance) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign base     = {wcnt_q, 2'b00};
  assign lenx     = {2'b00, len_q};
  assign last_idx = (lenx + CW'(8)) >> 6;
  assign blk_idx  = {6'b0, wcnt_q[LEN_W-1:4]};
  assign blk_last = (blk_idx == last_idx);
  assign slot     = wcnt_q[3:0];
  assign len_slot = blk_last && (wcnt_q[3:1] == 3'b111);
  assign bitlen   = 64'({len_q, 3'b000});
  assign rem      = lenx - base;

  // length field: high word first for SHA-1, low word first for MD5
  always_comb begin
    if (algo == ALG_MD5) len_w = wcnt_q[0] ? bitlen[63:32] : bitlen[31:0];
    else                 len_w = wcnt_q[0] ? bitlen[31:0]  : bitlen[63:32];
  end

  always_comb begin
    need_in  = 1'b0;
    stream_w = 32'h0;
    if (len_slot) begin
      stream_w = 32'h0;
    end else if ((base + CW'(4)) <= lenx) begin
      need_in  = 1'b1;
      stream_w = in_data;
    end else if (base < lenx) begin
      need_in = 1'b1;
      case (rem[1:0])
        2'd1:    stream_w = {in_data[31:24], 8'h80, 16'h0};
        2'd2:    stream_w = {in_data[31:16], 8'h80, 8'h0};
        default: stream_w = {in_data[31:8], 8'h80};
      endcase
    end else if (base == lenx) begin
      stream_w = 32'h8000_0000;
    end
  end

  assign word = len_slot ? len_w : ((algo == ALG_MD5) ? bswap32(stream_w) : stream_w);

  AST_LEN_SLOT_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    len_slot |-> !need_in); // R6

endmodule

// File: rtl/dual_hash_wexp.sv
module dual_hash_wexp
  import dual_hash_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        algo,
  input  logic        fill_we,
  input  logic [3:0]  fill_slot,
  input  logic [31:0] fill_word,
  input  logic        step_en,
  input  logic [6:0]  step,
  output logic [31:0] wj
);
  localparam int WIN = 16;

  logic [31:0] win_q [WIN];
  logic [3:0]  i3, i8, i14, i16;
  logic [31:0] sha_w, md5_w;
  logic        sha_wb;

  assign i3  = step[3:0] + 4'd13;
  assign i8  = step[3:0] + 4'd8;
  assign i14 = step[3:0] + 4'd2;
  assign i16 = step[3:0];

  assign sha_w  = (step < 7'd16) ? win_q[step[3:0]]
                : rotl32(win_q[i3] ^ win_q[i8] ^ win_q[i14] ^ win_q[i16], 5'd1);
  assign md5_w  = win_q[md5_idx(step)];
  assign wj     = (algo == ALG_MD5) ? md5_w : sha_w;
  assign sha_wb = step_en && (algo == ALG_SHA1) && (step >= 7'd16);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win_q[i] <= '0;
    end else if (fill_we) begin
      win_q[fill_slot] <= fill_word;
    end else if (sha_wb) begin
      win_q[i16] <= sha_w;
    end
  end

  AST_NO_FILL_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> !fill_we); // R5

endmodule

// File: rtl/dual_hash_const.sv
module dual_hash_const
  import dual_hash_pkg::*;
(
  input  logic        algo,
  input  logic [6:0]  step,
  output logic [31:0] tj,
  output logic [4:0]  shamt
);
  assign tj    = (algo == ALG_MD5) ? md5_k(step[5:0]) : sha1_k(step);
  assign shamt = (algo == ALG_MD5) ? md5_shift(step) : 5'd0;
endmodule

// File: rtl/dual_hash_round.sv
module dual_hash_round
  import dual_hash_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         algo,
  input  logic         msg_init,
  input  logic         blk_init,
  input  logic         step_en,
  input  logic         blk_end,
  input  logic [6:0]   step,
  input  logic [31:0]  wj,
  input  logic [31:0]  tj,
  input  logic [4:0]   shamt,
  output logic [159:0] h_flat
);
  localparam int NW = 5;
  localparam logic [31:0] IV [NW] = '{32'h67452301, 32'hefcdab89, 32'h98badcfe,
                                      32'h10325476, 32'hc3d2e1f0};

  logic [31:0] h_q [NW];
  logic [31:0] v_q [NW];
  logic [31:0] nx  [NW];
  logic [31:0] sha_t, md5_x;

  assign sha_t = rotl32(v_q[0], 5'd5) + sha1_f(step, v_q[1], v_q[2], v_q[3])
               + v_q[4] + tj + wj;
  assign md5_x = v_q[0] + md5_f(step, v_q[1], v_q[2], v_q[3]) + tj + wj;

  always_comb begin
    if (algo == ALG_MD5) begin
      nx[0] = v_q[3];
      nx[1] = v_q[1] + rotl32(md5_x, shamt);
      nx[2] = v_q[1];
      nx[3] = v_q[2];
      nx[4] = v_q[4];
    end else begin
      nx[0] = sha_t;
      nx[1] = v_q[0];
      nx[2] = rotl32(v_q[1], 5'd30);
      nx[3] = v_q[2];
      nx[4] = v_q[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        h_q[i] <= '0;
        v_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (msg_init)     h_q[i] <= IV[i];
        else if (blk_end) h_q[i] <= h_q[i] + nx[i];
        if (blk_init)     v_q[i] <= h_q[i];
        else if (step_en) v_q[i] <= nx[i];
      end
    end
  end

  assign h_flat = {h_q[0], h_q[1], h_q[2], h_q[3], h_q[4]};

  AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_end && !msg_init) |=> $stable(h_flat)); // R8

endmodule

// File: rtl/dual_hash_engine.sv
module dual_hash_engine
  import dual_hash_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             algo_sel,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             busy,
  output logic             done,
  output logic [159:0]     digest
);
  localparam logic [6:0] SHA_LAST = 7'd79;
  localparam logic [6:0] MD5_LAST = 7'd63;

  eng_state_t  state_q;
  logic        algo_q, done_q, last_q;
  logic [6:0]  step_q, last_step;
  logic        start_ok, fill_go, blk_init, blk_end, step_en;
  logic        need_in, blk_last;
  logic [31:0] pad_word, wj, tj;
  logic [3:0]  slot;
  logic [4:0]  shamt;
  logic [159:0] h_flat;

  assign last_step = (algo_q == ALG_MD5) ? MD5_LAST : SHA_LAST;
  assign start_ok  = start && (state_q == ST_IDLE);
  assign fill_go   = (state_q == ST_FILL) && (!need_in || in_valid);
  assign blk_init  = fill_go && (slot == 4'd15);
  assign step_en   = (state_q == ST_RUN);
  assign blk_end   = step_en && (step_q == last_step);

  assign in_ready = (state_q == ST_FILL) && need_in;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      algo_q  <= ALG_SHA1;
      step_q  <= '0;
      done_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          algo_q  <= algo_sel;
          done_q  <= 1'b0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (blk_init) begin
          state_q <= ST_RUN;
          step_q  <= '0;
          last_q  <= blk_last;
        end
        ST_RUN: begin
          step_q <= step_q + 1'b1;
          if (blk_end) begin
            if (last_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  dual_hash_pad #(.LEN_W(LEN_W)) u_pad (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .len_in(msg_len), .algo(algo_q),
    .advance(fill_go), .in_data(in_data), .need_in(need_in), .word(pad_word),
    .slot(slot), .blk_last(blk_last)
  );

  dual_hash_wexp u_wexp (
    .clk(clk), .rst_n(rst_n), .algo(algo_q), .fill_we(fill_go), .fill_slot(slot),
    .fill_word(pad_word), .step_en(step_en), .step(step_q), .wj(wj)
  );

  dual_hash_const u_const (
    .algo(algo_q), .step(step_q), .tj(tj), .shamt(shamt)
  );

  dual_hash_round u_round (
    .clk(clk), .rst_n(rst_n), .algo(algo_q), .msg_init(start_ok), .blk_init(blk_init),
    .step_en(step_en), .blk_end(blk_end), .step(step_q), .wj(wj), .tj(tj),
    .shamt(shamt), .h_flat(h_flat)
  );

  assign digest = (algo_q == ALG_MD5)
    ? {32'h0, bswap32(h_flat[159:128]), bswap32(h_flat[127:96]),
       bswap32(h_flat[95:64]), bswap32(h_flat[63:32])}
    : h_flat;

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(digest))); // R8
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done)); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(algo_q)); // R9
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (step_q <= last_step)); // R7

endmodule

// File: tb/tb_dual_hash_engine.sv
`timescale 1ns/1ps
module tb_dual_hash_engine;
  localparam int LEN_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             algo_sel = 1'b0;
  logic [LEN_W-1:0] msg_len = '0;
  logic             in_valid = 1'b0;
  logic [31:0]      in_data = '0;
  wire              in_ready, busy, done;
  wire  [159:0]     digest;

  dual_hash_engine #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .algo_sel(algo_sel), .msg_len(msg_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .busy(busy),
    .done(done), .digest(digest)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit prev_done = 1'b0;
  logic [7:0]   mb [0:127];
  logic [159:0] exp_q [$];
  string        tag_q [$];

  task automatic chk(input bit ok, input string req, input logic [159:0] act,
                     input logic [159:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] word_at(input int i);
    return {mb[4*i], mb[4*i+1], mb[4*i+2], mb[4*i+3]};
  endfunction

  // scoreboard monitor: pops one expected digest per rising done
  initial begin
    forever begin
      @(negedge clk);
      if (done && !prev_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 done without pending message", digest, 160'h0);
        end else begin
          logic [159:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(digest == e, t, digest, e);
        end
      end
      prev_done = done;
    end
  end

  // driver: pushes expectation, feeds words, measures latency and word count
  task automatic run_msg(input string s, input bit alg, input logic [159:0] expv,
                         input string tag, input bit stall, input bit poke,
                         input int lat);
    int len, nwords, idx, acc, cyc;
    bit pend;
    len    = s.len();
    nwords = (len + 3) / 4;
    for (int i = 0; i < 128; i++) mb[i] = (i < len) ? s[i] : 8'hA5;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    idx = 0; acc = 0; cyc = 0; pend = 1'b0;
    @(negedge clk);
    algo_sel = alg;
    msg_len  = LEN_W'(len);
    start    = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (pend) begin idx++; acc++; end
      if (done) break;
      if (cyc > 5000) begin
        chk(1'b0, "R7 message never completed", 160'(cyc), 160'(lat));
        break;
      end
      if (poke && cyc == 40) begin   // R9: stray start mid-message
        start    = 1'b1;
        algo_sel = ~alg;
        msg_len  = LEN_W'(5);
      end
      in_valid = (idx < nwords) && !(stall && (cyc % 3 == 0));
      in_data  = word_at(idx);
      pend     = in_ready && in_valid;
    end
    in_valid = 1'b0;
    chk(acc == nwords, {"R5 words accepted: ", tag}, 160'(acc), 160'(nwords));
    if (lat > 0)
      chk(cyc == lat + 1, {"R7 latency: ", tag}, 160'(cyc - 1), 160'(lat));
    repeat (20) @(negedge clk);
    chk(done && (digest == expv), {"R8 held result: ", tag}, digest, expv);
    chk(!in_ready, {"R5 ready low after done: ", tag}, 160'(in_ready), 160'h0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!done && !busy && !in_ready, "R1 flags in reset", {157'h0, done, busy, in_ready}, 160'h0);
    chk(digest == 160'h0, "R1 digest in reset", digest, 160'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !in_ready && digest == 160'h0, "R1 after release", digest, 160'h0);

    run_msg("", 1'b0, 160'hda39a3ee5e6b4b0d3255bfef95601890afd80709,
            "R2 R6 SHA-1 empty", 1'b0, 1'b0, 96);
    run_msg("", 1'b1, {32'h0, 128'hd41d8cd98f00b204e9800998ecf8427e},
            "R3 R6 MD5 empty", 1'b0, 1'b0, 80);
    run_msg("abc", 1'b0, 160'ha9993e364706816aba3e25717850c26c9cd0d89d,
            "R2 R4 SHA-1 abc", 1'b0, 1'b0, 96);
    run_msg("abc", 1'b1, {32'h0, 128'h900150983cd24fb0d6963f7d28e17f72},
            "R3 R4 R11 MD5 abc", 1'b0, 1'b0, 80);
    run_msg("abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq", 1'b0,
            160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1,
            "R6 SHA-1 56-byte two blocks", 1'b0, 1'b0, 0);
    run_msg("12345678901234567890123456789012345678901234567890123456789012345678901234567890",
            1'b1, {32'h0, 128'h57edf4a22be3c955ac49da2e2107b67a},
            "R3 MD5 80-byte two blocks", 1'b0, 1'b0, 0);
    run_msg("message digest", 1'b1, {32'h0, 128'hf96b697d7cb7938d525a2f31aaf161d0},
            "R10 MD5 with stalls", 1'b1, 1'b0, 0);
    run_msg("abc", 1'b0, 160'ha9993e364706816aba3e25717850c26c9cd0d89d,
            "R9 R10 R11 SHA-1 stray start", 1'b1, 1'b1, 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8 every message completed", 160'(exp_q.size()), 160'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule